// File: doc/BRIEF.md
# Two-Channel Break Condition Matcher

A debug break unit that watches bus access cycles on two compare channels, A and B. Each channel holds a compare address and a set of enabled access kinds: instruction fetch, data read and data write. When an observed access agrees with a channel, that channel's sticky match flag is set. The flag stays set until software clears it through the control register.

In independent mode each channel raises a break request on its own, if that channel's break enable is set. A flag is still set when the enable is clear. In sequential mode a channel A match only arms the unit. A later channel B match then raises the break and sets the B flag alone. Writing the mode bit low drops an arm that is still pending.

A small state machine sets the mode, with three states. `SEQ_OFF` is independent mode. `SEQ_WAIT_A` is sequential mode with nothing armed. `SEQ_ARMED` is sequential mode after an A match. The transitions are:
- *enter_seq* (`SEQ_OFF`→`SEQ_WAIT_A`): a control write with the mode bit high.
- *arm* (`SEQ_WAIT_A`→`SEQ_ARMED`): an A match.
- *fire* (`SEQ_ARMED`→`SEQ_WAIT_A`): a B match.
- *leave_seq* (any sequential state →`SEQ_OFF`): a control write with the mode bit low.

Top module: `brk_match_unit`

## Requirements
- R1: After reset `brk_req`, `flag_a` and `flag_b` are 0 and the unit is in independent mode.
- R2: A channel matches only when `bus_valid` is 1, `bus_addr` equals its compare address, and the enable bit for `bus_kind` is set in its qualifier. `bus_kind` encodings are 0 = fetch (qualifier bit 0), 1 = data read (bit 1), 2 = data write (bit 2). Kind 3 never matches.
- R3: In independent mode a match sets that channel's flag on the clock edge that samples the access. The flag then stays 1 with no hardware clear.
- R4: A write to control register 0 clears flag A when wdata bit 0 is 0, and clears flag B when bit 1 is 0. Writing 1 to either bit leaves that flag unchanged. A match in the same cycle as a clear leaves the flag set.
- R5: A channel whose break enable is 0 still sets its flag on a match, but raises no break request. The enables are control bit 2 for A and bit 3 for B.
- R6: In independent mode `brk_req` is high for the cycle after an access. It is the OR of the enabled matches of both channels.
- R7: With control bit 4 (sequential mode) set, an A match arms the unit without changing flag A. A B match on a later cycle raises `brk_req` in the cycle after that access, sets flag B, and leaves flag A as it was.
- R8: In sequential mode a B match with no pending arm raises no break and sets no flag.
- R9: In sequential mode, if A and B match in the same cycle while unarmed, only the arm is recorded and no break is raised.
- R10: A control write with bit 4 at 0 discards a pending arm. Re-entering sequential mode then requires a fresh A match.
- R11: After a sequential break the arm is consumed, so a following B match alone raises nothing.
- R12: Control bits 7:5 are the channel A qualifier and bits 10:8 the channel B qualifier. Register 1 holds the A compare address and register 2 the B compare address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 compare A, 2 compare B |
| cfg_wdata | input | ADDR_W | Register write data |
| bus_valid | input | 1 | Observed access is valid this cycle |
| bus_addr | input | ADDR_W | Observed access address |
| bus_kind | input | 2 | Access kind: 0 fetch, 1 read, 2 write, 3 none |
| brk_req | output | 1 | Break request, one cycle per breaking access |
| flag_a | output | 1 | Sticky match flag, channel A |
| flag_b | output | 1 | Sticky match flag, channel B |

## Verification
The assertions assume that at most one observed access arrives per cycle. They also assume that a register write and an access may coincide, and that matches in that cycle use the configuration from before the write. The stimulus drives one access or one write per cycle, and one case on purpose puts a flag clear and a match in the same cycle. To get simultaneous A and B matches, both compare addresses are set to the same value, since there is only one access per cycle. `ADDR_W` is assumed to be at least 11 so that the control fields fit.

// File: rtl/bkm_pkg.sv
package bkm_pkg;

    // Access kinds observed on the bus
    typedef enum logic [1:0] {
        KIND_FETCH  = 2'd0,
        KIND_DREAD  = 2'd1,
        KIND_DWRITE = 2'd2,
        KIND_NONE   = 2'd3
    } acc_kind_e;

    // Register select values
    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_CMP_A = 2'd1,
        REG_CMP_B = 2'd2,
        REG_RSVD  = 2'd3
    } reg_sel_e;

    // Sequencer states
    typedef enum logic [1:0] {
        SEQ_OFF    = 2'd0,
        SEQ_WAIT_A = 2'd1,
        SEQ_ARMED  = 2'd2
    } seq_state_e;

    localparam int NUM_CH      = 2;
    localparam int QUAL_W      = 3;
    localparam int CTL_FLAG_LO = 0;   // flag A at 0, flag B at 1
    localparam int CTL_EN_LO   = 2;   // enable A at 2, enable B at 3
    localparam int CTL_SEQ     = 4;
    localparam int CTL_QUAL_LO = 5;   // qualifier A 7:5, qualifier B 10:8
    localparam int CTL_W       = CTL_QUAL_LO + NUM_CH * QUAL_W;

    typedef struct packed {
        logic [QUAL_W-1:0] qual;
        logic              brk_en;
    } chan_cfg_t;

endpackage

// File: rtl/bkm_regs.sv
module bkm_regs
    import bkm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic [1:0]                       cfg_addr,
    input  logic [ADDR_W-1:0]                cfg_wdata,
    input  logic [NUM_CH-1:0]                set_flag,
    output logic [NUM_CH-1:0][ADDR_W-1:0]    cmp_addr,
    output chan_cfg_t [NUM_CH-1:0]           ch_cfg,
    output logic [NUM_CH-1:0]                flags,
    output logic                             ctrl_wr,
    output logic                             wr_seq
);

    logic ctrl_sel;

    always_comb begin
        ctrl_sel = (cfg_addr == REG_CTRL);
        ctrl_wr  = cfg_we && ctrl_sel;
        wr_seq   = cfg_wdata[CTL_SEQ];
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic addr_hit;
        logic clr_req;

        always_comb begin
            addr_hit = cfg_we && (cfg_addr == ((ch == 0) ? REG_CMP_A : REG_CMP_B));
            clr_req  = ctrl_wr && !cfg_wdata[CTL_FLAG_LO + ch];
        end

        // Compare address
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp_addr[ch] <= '0;
            end else if (addr_hit) begin
                cmp_addr[ch] <= cfg_wdata;
            end
        end

        // Qualifier and break enable
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ch_cfg[ch] <= '0;
            end else if (ctrl_wr) begin
                ch_cfg[ch].qual   <= cfg_wdata[CTL_QUAL_LO + ch*QUAL_W +: QUAL_W];
                ch_cfg[ch].brk_en <= cfg_wdata[CTL_EN_LO + ch];
            end
        end

        // Sticky flag: hardware set wins over a software clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[ch] <= 1'b0;
            end else begin
                flags[ch] <= (flags[ch] && !clr_req) || set_flag[ch];
            end
        end
    end

endmodule

// File: rtl/bkm_chan.sv
module bkm_chan
    import bkm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cmp_addr,
    input  logic [QUAL_W-1:0] qual,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_kind,
    output logic              hit
);

    logic kind_ok;
    logic addr_eq;

    always_comb begin
        unique case (acc_kind_e'(bus_kind))
            KIND_FETCH:  kind_ok = qual[0];
            KIND_DREAD:  kind_ok = qual[1];
            KIND_DWRITE: kind_ok = qual[2];
            default:     kind_ok = 1'b0;
        endcase
        addr_eq = (bus_addr == cmp_addr);
        hit     = bus_valid && addr_eq && kind_ok;
    end

endmodule

// File: rtl/bkm_seq.sv
module bkm_seq
    import bkm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              wr_seq,
    input  logic [NUM_CH-1:0] hit,
    input  logic [NUM_CH-1:0] brk_en,
    output logic [NUM_CH-1:0] set_flag,
    output logic              brk_req,
    output seq_state_e        state
);

    seq_state_e state_nxt;
    logic       brk_nxt;

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            SEQ_OFF: begin
                if (ctrl_wr && wr_seq) state_nxt = SEQ_WAIT_A;       // enter_seq
            end
            SEQ_WAIT_A: begin
                if (ctrl_wr && !wr_seq) state_nxt = SEQ_OFF;         // leave_seq
                else if (hit[0])        state_nxt = SEQ_ARMED;       // arm
            end
            SEQ_ARMED: begin
                if (ctrl_wr && !wr_seq) state_nxt = SEQ_OFF;         // leave_seq
                else if (hit[1])        state_nxt = SEQ_WAIT_A;      // fire
            end
            default: state_nxt = SEQ_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_OFF;
        end else begin
            state <= state_nxt;
        end
    end

    // Output decode
    always_comb begin
        set_flag = '0;
        brk_nxt  = 1'b0;
        unique case (state)
            SEQ_OFF: begin
                set_flag = hit;
                brk_nxt  = |(hit & brk_en);
            end
            SEQ_WAIT_A: begin
                set_flag = '0;
                brk_nxt  = 1'b0;
            end
            SEQ_ARMED: begin
                set_flag[1] = hit[1];
                brk_nxt     = hit[1] && brk_en[1];
            end
            default: begin
                set_flag = '0;
                brk_nxt  = 1'b0;
            end
        endcase
    end

    // Registered break request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_req <= 1'b0;
        end else begin
            brk_req <= brk_nxt;
        end
    end

endmodule

// File: rtl/brk_match_unit.sv
module brk_match_unit
    import bkm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_kind,
    output logic              brk_req,
    output logic              flag_a,
    output logic              flag_b
);

    logic [NUM_CH-1:0][ADDR_W-1:0] cmp_addr;
    chan_cfg_t [NUM_CH-1:0]        ch_cfg;
    logic [NUM_CH-1:0]             flags;
    logic [NUM_CH-1:0]             set_flag;
    logic [NUM_CH-1:0]             hit;
    logic [NUM_CH-1:0]             brk_en;
    logic                          ctrl_wr;
    logic                          wr_seq;
    logic                          en_a;
    logic                          en_b;
    seq_state_e                    seq_state;

    bkm_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .set_flag (set_flag),
        .cmp_addr (cmp_addr),
        .ch_cfg   (ch_cfg),
        .flags    (flags),
        .ctrl_wr  (ctrl_wr),
        .wr_seq   (wr_seq)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        bkm_chan #(.ADDR_W(ADDR_W)) chan_i (
            .cmp_addr (cmp_addr[ch]),
            .qual     (ch_cfg[ch].qual),
            .bus_valid(bus_valid),
            .bus_addr (bus_addr),
            .bus_kind (bus_kind),
            .hit      (hit[ch])
        );
        assign brk_en[ch] = ch_cfg[ch].brk_en;
    end

    bkm_seq seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .wr_seq  (wr_seq),
        .hit     (hit),
        .brk_en  (brk_en),
        .set_flag(set_flag),
        .brk_req (brk_req),
        .state   (seq_state)
    );

    assign en_a   = brk_en[0];
    assign en_b   = brk_en[1];
    assign flag_a = flags[0];
    assign flag_b = flags[1];

endmodule

// File: rtl/brk_match_unit_chk.sv
module brk_match_unit_chk
    import bkm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [1:0]        cfg_addr,
    input logic [ADDR_W-1:0] cfg_wdata,
    input logic              brk_req,
    input logic              flag_a,
    input logic              flag_b,
    input logic              en_a,
    input logic              en_b,
    input seq_state_e        state
);

    logic ctl_w;
    assign ctl_w = cfg_we && (cfg_addr == REG_CTRL);

    AST_FLAG_A_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_a && !(ctl_w && !cfg_wdata[CTL_FLAG_LO])) |=> flag_a);      // R4

    AST_FLAG_B_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_b && !(ctl_w && !cfg_wdata[CTL_FLAG_LO+1])) |=> flag_b);    // R3

    AST_BRK_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> (flag_a || flag_b));                                   // R6

    AST_BRK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> $past(en_a || en_b));                                  // R5

    AST_SEQ_KEEPS_A: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SEQ_OFF && !flag_a) |=> !flag_a);                        // R7

    AST_SEQ_BRK_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_req && $past(state) != SEQ_OFF) |-> $past(state) == SEQ_ARMED); // R8

    AST_LEAVE_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_w && !cfg_wdata[CTL_SEQ]) |=> state == SEQ_OFF);              // R10

endmodule

bind brk_match_unit brk_match_unit_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .brk_req  (brk_req),
    .flag_a   (flag_a),
    .flag_b   (flag_b),
    .en_a     (en_a),
    .en_b     (en_b),
    .state    (seq_state)
);

// File: tb/brk_match_unit_tb_top.sv
`timescale 1ns/100ps
module brk_match_unit_tb_top;

    localparam int AW = 32;
    localparam logic [2:0] QF = 3'b001;
    localparam logic [2:0] QR = 3'b010;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          bus_valid = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [1:0]    bus_kind = 2'd3;
    logic          brk_req, flag_a, flag_b;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        logic  brk;
        logic  fa;
        logic  fb;
        string req;
    } exp_t;

    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    brk_match_unit #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_kind(bus_kind), .brk_req(brk_req), .flag_a(flag_a), .flag_b(flag_b)
    );

    function automatic logic [AW-1:0] ctl(bit ka, bit kb, bit ena, bit enb, bit sq,
                                          logic [2:0] qa, logic [2:0] qb);
        return {{(AW-11){1'b0}}, qb, qa, sq, enb, ena, kb, ka};
    endfunction

    // Driver: one cycle of stimulus, expected outputs pushed for the next edge
    task automatic cyc(input bit we, input logic [1:0] a, input logic [AW-1:0] wd,
                       input bit v, input logic [AW-1:0] ba, input logic [1:0] k,
                       input bit eb, input bit efa, input bit efb, input string req);
        @(negedge clk);
        cfg_we = we; cfg_addr = a; cfg_wdata = wd;
        bus_valid = v; bus_addr = ba; bus_kind = k;
        sb_q.push_back('{eb, efa, efb, req});
    endtask

    task automatic wr(input logic [1:0] a, input logic [AW-1:0] wd,
                      input bit eb, input bit efa, input bit efb, input string req);
        cyc(1'b1, a, wd, 1'b0, '0, 2'd3, eb, efa, efb, req);
    endtask

    task automatic acc(input logic [AW-1:0] ba, input logic [1:0] k,
                       input bit eb, input bit efa, input bit efb, input string req);
        cyc(1'b0, 2'd0, '0, 1'b1, ba, k, eb, efa, efb, req);
    endtask

    // Monitor: compare after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if ({brk_req, flag_a, flag_b} !== {e.brk, e.fa, e.fb}) begin
                    errors++;
                    $display("FAIL %s: brk/fa/fb actual=%b%b%b expected=%b%b%b",
                             e.req, brk_req, flag_a, flag_b, e.brk, e.fa, e.fb);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog (R1 sequence hung): actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b0, 2'd0, '0, 1'b0, '0, 2'd3, 0, 0, 0, "R1 reset state");
        wr(2'd1, 32'h100, 0, 0, 0, "R1 after compare A write");
        wr(2'd2, 32'h200, 0, 0, 0, "R12 compare B write");
        wr(2'd0, ctl(1,1,1,1,0,QF,QR), 0, 0, 0, "R12 control write");
        acc(32'h100, 2'd0, 1, 1, 0, "R3 A fetch match");
        cyc(1'b0, 2'd0, '0, 1'b0, '0, 2'd3, 0, 1, 0, "R3 flag sticky");
        acc(32'h100, 2'd1, 0, 1, 0, "R2 kind not qualified");
        acc(32'h101, 2'd0, 0, 1, 0, "R2 address mismatch");
        acc(32'h200, 2'd3, 0, 1, 0, "R2 kind 3 never matches");
        acc(32'h200, 2'd1, 1, 1, 1, "R6 B read match");
        cyc(1'b0, 2'd0, '0, 1'b0, 32'h100, 2'd0, 0, 1, 1, "R2 invalid access ignored");
        wr(2'd0, ctl(0,1,1,1,0,QF,QR), 0, 0, 1, "R4 clear A only");
        wr(2'd0, ctl(1,0,1,1,0,QF,QR), 0, 0, 0, "R4 clear B, 1 keeps A at 0");
        acc(32'h100, 2'd0, 1, 1, 0, "R3 A match again");
        cyc(1'b1, 2'd0, ctl(0,1,1,1,0,QF,QR), 1'b1, 32'h100, 2'd0, 1, 1, 0,
            "R4 set wins over clear");
        wr(2'd0, ctl(0,0,0,1,0,QF,QR), 0, 0, 0, "R5 clear both, A disabled");
        acc(32'h100, 2'd0, 0, 1, 0, "R5 flag without break");
        acc(32'h200, 2'd1, 1, 1, 1, "R6 B break while A disabled");
        // Sequential mode
        wr(2'd0, ctl(0,0,1,1,1,QF,QR), 0, 0, 0, "R7 enter sequential");
        acc(32'h200, 2'd1, 0, 0, 0, "R8 B without arm");
        acc(32'h100, 2'd0, 0, 0, 0, "R7 A arms, no A flag");
        cyc(1'b0, 2'd0, '0, 1'b0, '0, 2'd3, 0, 0, 0, "R7 armed idle");
        acc(32'h200, 2'd1, 1, 0, 1, "R7 B after A breaks");
        acc(32'h200, 2'd1, 0, 0, 1, "R11 arm consumed");
        acc(32'h100, 2'd0, 0, 0, 1, "R10 arm again");
        wr(2'd0, ctl(1,1,1,1,0,QF,QR), 0, 0, 1, "R10 leave sequential");
        wr(2'd0, ctl(1,1,1,1,1,QF,QR), 0, 0, 1, "R10 re-enter sequential");
        acc(32'h200, 2'd1, 0, 0, 1, "R10 arm was discarded");
        // Same-cycle A and B
        wr(2'd2, 32'h100, 0, 0, 1, "R9 B address equals A");
        wr(2'd0, ctl(0,0,1,1,1,QF,QF), 0, 0, 0, "R9 clear flags");
        acc(32'h100, 2'd0, 0, 0, 0, "R9 simultaneous A and B arms only");
        acc(32'h100, 2'd0, 1, 0, 1, "R9 later B breaks");
        cyc(1'b0, 2'd0, '0, 1'b0, '0, 2'd3, 0, 0, 1, "R6 pulse ends");
        wr(2'd0, ctl(0,0,1,1,0,QF,QF), 0, 0, 0, "R6 back to independent");
        acc(32'h100, 2'd0, 1, 1, 1, "R6 both channels on one access");
        cyc(1'b0, 2'd0, '0, 1'b0, '0, 2'd3, 0, 1, 1, "R3 both sticky");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule